// File: doc/BRIEF.md
# Bidirectional I2C Segment Repeater

This block joins two open-drain I2C segments, called bus 0 and bus 1, and copies every LOW on the data line and on the clock line from one segment to the other. It has no direction input. For each line it records which segment pulled the line LOW first. It then drives only the opposite segment, so its own pull-down is never mistaken for a device's LOW and the two sides cannot lock each other LOW. Each line is read through a synchronizer. Each line is driven through an output enable, where a 1 pulls the wire LOW and a 0 releases it to the external pull-up.

A connect request input decides whether the segments are linked. Bus 0 is the master-side segment, and the block watches it for START and STOP conditions. A change of the request takes effect only while no transfer is in flight on bus 0. A transfer that has started therefore keeps its link until its STOP, and a segment is never joined in the middle of a transfer. Clock stretching and arbitration pass across the link. When the first device on a line lets go while a device on the far segment still holds that line LOW, ownership moves to the far segment and the LOW is carried back.

Top module: `i2c_seg_repeater`

## Requirements
- R1: While reset is asserted, and in the cycles after it, all four output enables are 0. After reset the segments are linked, as if the connect request were pulled HIGH.
- R2: A LOW applied by a device to a line on either segment makes the block drive the same line on the other segment LOW three clock cycles later (two synchronizer stages plus the ownership register). The copy is not inverted. When the device releases the line, the copied LOW is released three cycles later.
- R3: The block never drives the segment that owns a line. After the owner releases the line, the LOW the block had been driving on the other segment is not taken as a new device LOW, and both sides of that line end HIGH with both enables at 0.
- R4: While the block drives a segment LOW, a device that also pulls that segment LOW keeps the block's drive in place for as long as the owner holds its LOW. When the owner releases, the remaining LOW is carried back to the first segment until that device also releases.
- R5: If both segments of one line go LOW in the same sample, bus 0 becomes the owner and only the bus 1 side is driven.
- R6: With the connect request LOW and the bus idle, no LOW is copied in either direction and all enables stay at 0. Raising the request again restores copying.
- R7: A change of the connect request between a START and the following STOP is deferred. A link that is up stays up until after the STOP, and a link that is down stays down until after the STOP.
- R8: START is recognised on bus 0 as the data line falling while the clock line is HIGH. STOP is recognised as the data line rising while the clock line is HIGH. Both are recognised whether or not the segments are linked.
- R9: The data channel and the clock channel are independent. A LOW on one line never drives the other line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_req | input | 1 | Connect request, active HIGH |
| b0_sda_i | input | 1 | Bus 0 data line level |
| b0_scl_i | input | 1 | Bus 0 clock line level |
| b1_sda_i | input | 1 | Bus 1 data line level |
| b1_scl_i | input | 1 | Bus 1 clock line level |
| b0_sda_oe | output | 1 | 1 pulls bus 0 data LOW |
| b0_scl_oe | output | 1 | 1 pulls bus 0 clock LOW |
| b1_sda_oe | output | 1 | 1 pulls bus 1 data LOW |
| b1_scl_oe | output | 1 | 1 pulls bus 1 clock LOW |

## Verification
The in-line assertions are checked on every cycle. They check that a new drive is always preceded by a LOW on the opposite segment, that a released drive is never followed at once by a drive back onto the owner, that a drive holds while its owner is LOW, that a lost link clears every drive, and that the link cannot move while a transfer is open. Only the bench's scenarios can show the end-to-end effects. These are the three-cycle copy latency in both directions, the clean return to HIGH with no lock-up, the hand-back of a stretched clock, the tie-break on simultaneous LOWs, and the deferral of a connect change to the next STOP.

// File: rtl/i2crep_pkg.sv
// Shared types for the segment repeater.
package i2crep_pkg;
    // Which segment currently holds a line LOW.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_SIDE0 = 2'd1,
        OWN_SIDE1 = 2'd2
    } owner_t;
endpackage

// File: rtl/i2crep_sync.sv
// Multi-stage synchronizer for a vector of asynchronous levels.
// Assumes inputs are quasi-static relative to clk; resets to RST_VAL
// (lines idle HIGH, request connected).
module i2crep_sync #(
    parameter int          WIDTH   = 5,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One flop rank of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else if (s == 0) stage_q[s] <= d_async;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/i2crep_gate.sv
// Link gate: watches bus 0 for START/STOP and latches the connect request
// only while no transfer is open. Assumes synchronized inputs.
module i2crep_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic sda_s,
    input  logic scl_s,
    output logic link_en,
    output logic busy
);
    logic sda_q;
    logic start_seen;
    logic stop_seen;

    // Edge qualification against the previous data sample.
    assign start_seen = scl_s &&  sda_q && !sda_s;
    assign stop_seen  = scl_s && !sda_q &&  sda_s;

    // Previous data sample, transfer flag and gated link state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_q   <= 1'b1;
            busy    <= 1'b0;
            link_en <= 1'b1;
        end else begin
            sda_q <= sda_s;
            if (start_seen)     busy <= 1'b1;
            else if (stop_seen) busy <= 1'b0;
            if (!busy && !start_seen) link_en <= req_s;
        end
    end

    // R7: the link does not move while a transfer is open.
    p_link_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(link_en));
    // R8: a START always opens a transfer.
    p_start_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> busy);
    // R8: a STOP always closes a transfer.
    p_stop_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !busy);
endmodule

// File: rtl/i2crep_line.sv
// One line channel: ownership tracking between two segments.
// The first side seen LOW owns the line; only the other side is driven.
// After a release, the formerly driven side is ignored for HOLD cycles
// so its own LOW, still in the synchronizer, is not echoed back.
module i2crep_line
    import i2crep_pkg::*;
#(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_en,
    input  logic s0_in,
    input  logic s1_in,
    output logic s0_oe,
    output logic s1_oe
);
    localparam int HW = $clog2(HOLD + 1);

    owner_t          state;
    logic [HW-1:0]   hold_cnt;
    logic            blank_s1;
    logic            hold_act;
    logic            s0_low;
    logic            s1_low;

    // Qualified LOW seen on each side, masking the just-released side.
    always_comb begin
        hold_act = (hold_cnt != '0);
        s0_low   = !s0_in && !(hold_act && !blank_s1);
        s1_low   = !s1_in && !(hold_act &&  blank_s1);
    end

    // Ownership state, hold-off counter and blanked side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= OWN_NONE;
            hold_cnt <= '0;
            blank_s1 <= 1'b0;
        end else if (!link_en) begin
            state    <= OWN_NONE;
            hold_cnt <= '0;
        end else begin
            case (state)
                OWN_NONE: begin
                    if (hold_act) hold_cnt <= hold_cnt - 1'b1;
                    if (s0_low) begin
                        state    <= OWN_SIDE0;
                        hold_cnt <= '0;
                    end else if (s1_low) begin
                        state    <= OWN_SIDE1;
                        hold_cnt <= '0;
                    end
                end
                OWN_SIDE0: begin
                    if (s0_in) begin
                        state    <= OWN_NONE;
                        hold_cnt <= HW'(HOLD);
                        blank_s1 <= 1'b1;
                    end
                end
                OWN_SIDE1: begin
                    if (s1_in) begin
                        state    <= OWN_NONE;
                        hold_cnt <= HW'(HOLD);
                        blank_s1 <= 1'b0;
                    end
                end
                default: state <= OWN_NONE;
            endcase
        end
    end

    assign s0_oe = (state == OWN_SIDE1);
    assign s1_oe = (state == OWN_SIDE0);

    // R2: a new drive on side 1 follows a LOW sampled on side 0.
    p_drive1_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s1_oe) |-> !$past(s0_in));
    // R2: a new drive on side 0 follows a LOW sampled on side 1.
    p_drive0_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s0_oe) |-> !$past(s1_in));
    // R3: releasing side 1 is never followed by driving side 0.
    p_no_echo1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s1_oe) |=> !s0_oe);
    // R3: releasing side 0 is never followed by driving side 1.
    p_no_echo0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s0_oe) |=> !s1_oe);
    // R4: the drive holds while the owner side stays LOW.
    p_hold_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_oe && !s0_in && link_en) |=> s1_oe);
    // R6: a dropped link releases both sides.
    p_unlink_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (!s0_oe && !s1_oe));
endmodule

// File: rtl/i2c_seg_repeater.sv
// Two-channel direction-less repeater between I2C segments 0 and 1.
// Lines are open drain: *_oe = 1 pulls the wire LOW. Bus 0 is the
// master side used for START/STOP tracking. Assumes external pull-ups.
module i2c_seg_repeater #(
    parameter int SYNC_STAGES = 2,
    parameter int RISE_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_req,
    input  logic b0_sda_i,
    input  logic b0_scl_i,
    input  logic b1_sda_i,
    input  logic b1_scl_i,
    output logic b0_sda_oe,
    output logic b0_scl_oe,
    output logic b1_sda_oe,
    output logic b1_scl_oe
);
    localparam int NLINES = 2;
    localparam int HOLD   = SYNC_STAGES + RISE_CYCLES;
    localparam int SW     = 2 * NLINES + 1;

    logic [SW-1:0]     raw_v;
    logic [SW-1:0]     syn_v;
    logic [NLINES-1:0] side0_s, side1_s, side0_oe, side1_oe;
    logic              req_s, link_en, busy;

    // Bit order: line 0 = data, line 1 = clock.
    assign raw_v = {link_req, b1_scl_i, b1_sda_i, b0_scl_i, b0_sda_i};

    i2crep_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw_v), .q_sync(syn_v)
    );

    assign side0_s = syn_v[1:0];
    assign side1_s = syn_v[3:2];
    assign req_s   = syn_v[4];

    i2crep_gate u_gate (
        .clk(clk), .rst_n(rst_n), .req_s(req_s),
        .sda_s(side0_s[0]), .scl_s(side0_s[1]),
        .link_en(link_en), .busy(busy)
    );

    generate
        for (genvar l = 0; l < NLINES; l++) begin : g_line
            i2crep_line #(.HOLD(HOLD)) u_line (
                .clk(clk), .rst_n(rst_n), .link_en(link_en),
                .s0_in(side0_s[l]), .s1_in(side1_s[l]),
                .s0_oe(side0_oe[l]), .s1_oe(side1_oe[l])
            );
        end
    endgenerate

    assign b0_sda_oe = side0_oe[0];
    assign b0_scl_oe = side0_oe[1];
    assign b1_sda_oe = side1_oe[0];
    assign b1_scl_oe = side1_oe[1];

    // R1: nothing is driven in the cycle right after reset.
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (side0_oe == '0 && side1_oe == '0));
    // R9: a drive on one line needs that line LOW on the far side.
    p_data_needs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b1_sda_oe) |-> !$past(side0_s[0]));
endmodule

// File: tb/test_i2c_seg_repeater.sv
module test_i2c_seg_repeater;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_req = 1'b1;
    // Device pull-downs: 1 means a device holds the line LOW.
    logic d0_sda = 1'b0, d0_scl = 1'b0, d1_sda = 1'b0, d1_scl = 1'b0;
    logic b0_sda_oe, b0_scl_oe, b1_sda_oe, b1_scl_oe;
    logic b0_sda, b0_scl, b1_sda, b1_scl;
    int vectors = 0;
    int misses = 0;

    always #4 clk = ~clk;

    // Wired-AND of device and repeater pull-downs.
    assign b0_sda = ~(d0_sda | b0_sda_oe);
    assign b0_scl = ~(d0_scl | b0_scl_oe);
    assign b1_sda = ~(d1_sda | b1_sda_oe);
    assign b1_scl = ~(d1_scl | b1_scl_oe);

    i2c_seg_repeater i_i2c_seg_repeater (
        .clk(clk), .rst_n(rst_n), .link_req(link_req),
        .b0_sda_i(b0_sda), .b0_scl_i(b0_scl),
        .b1_sda_i(b1_sda), .b1_scl_i(b1_scl),
        .b0_sda_oe(b0_sda_oe), .b0_scl_oe(b0_scl_oe),
        .b1_sda_oe(b1_sda_oe), .b1_scl_oe(b1_scl_oe)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        cyc(3);
        chk("R1", "all enables in reset",
            b0_sda_oe | b0_scl_oe | b1_sda_oe | b1_scl_oe, 1'b0);
        rst_n = 1'b1;
        cyc(4);
        chk("R1", "all enables after reset",
            b0_sda_oe | b0_scl_oe | b1_sda_oe | b1_scl_oe, 1'b0);
    endtask

    task automatic t_fwd_0to1;
        d0_sda = 1'b1;
        cyc(3);
        chk("R2", "bus1 data copied", b1_sda_oe, 1'b1);
        chk("R9", "bus1 clock untouched", b1_scl_oe, 1'b0);
        chk("R3", "owner side not driven", b0_sda_oe, 1'b0);
        d0_sda = 1'b0;
        cyc(3);
        chk("R2", "bus1 data released", b1_sda_oe, 1'b0);
        cyc(6);
        chk("R3", "no echo onto bus0 data", b0_sda_oe, 1'b0);
        chk("R3", "bus1 data high", b1_sda, 1'b1);
    endtask

    task automatic t_fwd_1to0;
        d1_scl = 1'b1;
        cyc(3);
        chk("R2", "bus0 clock copied", b0_scl_oe, 1'b1);
        chk("R9", "bus0 data untouched", b0_sda_oe, 1'b0);
        d1_scl = 1'b0;
        cyc(3);
        chk("R2", "bus0 clock released", b0_scl_oe, 1'b0);
        cyc(6);
        chk("R3", "no echo onto bus1 clock", b1_scl_oe, 1'b0);
        chk("R3", "bus0 clock high", b0_scl, 1'b1);
    endtask

    task automatic t_stretch;
        d0_scl = 1'b1;
        cyc(3);
        chk("R4", "clock copied to bus1", b1_scl_oe, 1'b1);
        d1_scl = 1'b1;
        cyc(4);
        chk("R4", "drive held while owner low", b1_scl_oe, 1'b1);
        d0_scl = 1'b0;
        cyc(10);
        chk("R4", "stretch carried to bus0", b0_scl_oe, 1'b1);
        chk("R4", "bus1 drive dropped", b1_scl_oe, 1'b0);
        d1_scl = 1'b0;
        cyc(3);
        chk("R4", "bus0 clock released", b0_scl_oe, 1'b0);
        cyc(6);
        chk("R3", "clock idle after stretch", b1_scl_oe | b0_scl_oe, 1'b0);
    endtask

    task automatic t_simul;
        d0_sda = 1'b1;
        d1_sda = 1'b1;
        cyc(3);
        chk("R5", "bus1 side driven", b1_sda_oe, 1'b1);
        chk("R5", "bus0 side not driven", b0_sda_oe, 1'b0);
        d0_sda = 1'b0;
        d1_sda = 1'b0;
        cyc(10);
        chk("R5", "both data released", b0_sda_oe | b1_sda_oe, 1'b0);
    endtask

    task automatic t_disable;
        link_req = 1'b0;
        cyc(6);
        d0_scl = 1'b1;
        d1_sda = 1'b1;
        cyc(5);
        chk("R6", "clock not copied when unlinked", b1_scl_oe, 1'b0);
        chk("R6", "data not copied when unlinked", b0_sda_oe, 1'b0);
        d0_scl = 1'b0;
        d1_sda = 1'b0;
        link_req = 1'b1;
        cyc(6);
        d0_scl = 1'b1;
        cyc(3);
        chk("R6", "copy restored after relink", b1_scl_oe, 1'b1);
        d0_scl = 1'b0;
        cyc(6);
    endtask

    task automatic t_busy_gate;
        d0_sda = 1'b1;                 // START: data falls, clock high
        cyc(3);
        chk("R8", "data copied at START", b1_sda_oe, 1'b1);
        link_req = 1'b0;
        cyc(8);
        d0_scl = 1'b1;
        cyc(3);
        chk("R7", "link kept during transfer", b1_scl_oe, 1'b1);
        d0_scl = 1'b0;
        cyc(5);
        d0_sda = 1'b0;                 // STOP: data rises, clock high
        cyc(8);
        d0_scl = 1'b1;
        cyc(4);
        chk("R7", "unlink applied after STOP", b1_scl_oe, 1'b0);
        d0_scl = 1'b0;
        cyc(4);
        d0_sda = 1'b1;                 // START while unlinked
        cyc(3);
        link_req = 1'b1;
        cyc(8);
        d0_scl = 1'b1;
        cyc(4);
        chk("R7", "relink deferred during transfer", b1_scl_oe, 1'b0);
        chk("R8", "START seen while unlinked", b1_sda_oe, 1'b0);
        d0_scl = 1'b0;
        cyc(4);
        d0_sda = 1'b0;                 // STOP
        cyc(8);
        d0_scl = 1'b1;
        cyc(3);
        chk("R7", "relink applied after STOP", b1_scl_oe, 1'b1);
        d0_scl = 1'b0;
        cyc(6);
    endtask

    initial begin
        t_reset();
        t_fwd_0to1();
        t_fwd_1to0();
        t_stretch();
        t_simul();
        t_disable();
        t_busy_gate();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(8 * 200000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule